// File: doc/BRIEF.md
# Piecewise Nonlinear Error Gain Stage

This block sits in a digitally closed power-supply loop, between the converter that digitises the output error and the digital compensator. Every error sample that arrives with its valid strobe is multiplied by a gain that depends on how large the error is. Small errors near zero get a low gain, which keeps the loop quiet and away from limit cycles. Large errors during a load step get a boosted gain, which shortens the transient.

The magnitude of the error goes to a bank of comparators, one for each programmable limit. Select logic turns the comparator results into a gain index, and a multiplexer uses that index to pick one of five programmable gains. Positive and negative errors each have their own limit set and their own gain set, so the response curve can be asymmetric. Gains are unsigned codes in steps of one quarter. The product is shifted right by two bits and then clipped to the signed width of the compensator input. The result appears one clock after the strobe. Software chooses the limits and gains.

Top module: `nlg_gain_stage`

## Requirements
- R1: While reset is applied, and up to the first strobe after it, `scaled_valid` is 0 and `scaled_err` is 0.
- R2: A sample strobed with `err_valid` at one rising edge gives exactly one output with `scaled_valid` high at the next rising edge. Back-to-back strobes give back-to-back outputs in the same order.
- R3: In a cycle with no strobe, `scaled_valid` is low and `scaled_err` keeps the last result.
- R4: The magnitude of the error is compared with four limits. Limit k sits at bits [12k+11:12k] of its limit bus. The highest-numbered limit that the magnitude strictly exceeds selects gain index k+1. If no limit is exceeded, gain index 0 is used. The limits need not be in ascending order.
- R5: A magnitude equal to a limit does not exceed it, so a tie takes the lower gain index.
- R6: An error above zero uses `pos_limits` and `pos_gains`. An error below zero uses `neg_limits` and `neg_gains` with magnitude −err. An error of zero gives an output of 0.
- R7: Gain index g is the code at bits [5g+4:5g] of the selected gain bus, in units of 0.25 (code 2 is 0.5, code 16 is 4.0). The output is floor(err × code / 4).
- R8: A result outside the signed 12-bit range is clipped to 2047 or −2048.
- R9: The most negative input, −2048, is handled with magnitude 2048 against the negative limits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_valid | input | 1 | Strobe marking a new error sample |
| err_in | input | 12 | Signed error sample in LSBs |
| pos_limits | input | 48 | Four unsigned magnitude limits used for positive errors |
| neg_limits | input | 48 | Four unsigned magnitude limits used for negative errors |
| pos_gains | input | 25 | Five quarter-step gain codes used for positive errors |
| neg_gains | input | 25 | Five quarter-step gain codes used for negative errors |
| scaled_valid | output | 1 | Output strobe, one cycle after `err_valid` |
| scaled_err | output | 12 | Scaled and clipped signed error |

## Verification
The assertions assume that the limit and gain buses stay constant while samples are in flight. They also assume that `err_valid` is a known level at every edge after reset. The bench meets both assumptions: it changes the tables only after the pipeline has drained, and it drives every input from tasks one nanosecond after a rising edge. It never leaves the strobe undriven.

// File: rtl/nlg_pkg.sv
package nlg_pkg;
  // Gains are stored with two fractional bits (quarter steps).
  localparam int unsigned GAIN_FRAC_BITS = 2;
endpackage

// File: rtl/nlg_select.sv
module nlg_select
  import nlg_pkg::*;
#(
  parameter int unsigned ERR_W      = 12,
  parameter int unsigned GAIN_W     = 5,
  parameter int unsigned NUM_LIMITS = 4
) (
  input  logic signed [ERR_W-1:0]            err,
  input  logic [NUM_LIMITS*ERR_W-1:0]        pos_limits,
  input  logic [NUM_LIMITS*ERR_W-1:0]        neg_limits,
  input  logic [(NUM_LIMITS+1)*GAIN_W-1:0]   pos_gains,
  input  logic [(NUM_LIMITS+1)*GAIN_W-1:0]   neg_gains,
  output logic [GAIN_W-1:0]                  gain
);
  localparam int unsigned NUM_GAINS = NUM_LIMITS + 1;
  localparam int unsigned SEL_W     = $clog2(NUM_GAINS);

  logic                  is_neg;
  logic [ERR_W-1:0]      mag;
  logic [NUM_LIMITS-1:0] exceed;
  logic [SEL_W-1:0]      sel;

  assign is_neg = err[ERR_W-1];
  // The most negative value negates to 2^(ERR_W-1), which is exact as unsigned.
  assign mag    = is_neg ? ERR_W'(-err) : ERR_W'(err);

  // One comparator per limit.
  for (genvar k = 0; k < NUM_LIMITS; k++) begin : g_cmp
    logic [ERR_W-1:0] lim;
    assign lim       = is_neg ? neg_limits[k*ERR_W +: ERR_W] : pos_limits[k*ERR_W +: ERR_W];
    assign exceed[k] = mag > lim;
  end

  // The highest-numbered exceeded limit wins.
  always_comb begin
    sel = '0;
    for (int k = 0; k < NUM_LIMITS; k++) begin
      if (exceed[k]) sel = SEL_W'(k + 1);
    end
  end

  always_comb begin
    if (is_neg) gain = neg_gains[sel*GAIN_W +: GAIN_W];
    else        gain = pos_gains[sel*GAIN_W +: GAIN_W];
  end

  always_comb begin
    assert_low_gain_R4: assert (!((exceed == '0) && (sel != '0)));
    assert_top_wins_R4: assert (!(exceed[NUM_LIMITS-1] && (sel != SEL_W'(NUM_LIMITS))));
  end
endmodule

// File: rtl/nlg_scale.sv
module nlg_scale
  import nlg_pkg::*;
#(
  parameter int unsigned ERR_W  = 12,
  parameter int unsigned GAIN_W = 5,
  parameter int unsigned OUT_W  = 12
) (
  input  logic signed [ERR_W-1:0] err,
  input  logic [GAIN_W-1:0]       gain,
  output logic signed [OUT_W-1:0] scaled
);
  localparam int unsigned PROD_W = ERR_W + GAIN_W + 1;
  localparam logic signed [PROD_W-1:0] OUT_MAX = PROD_W'((2 ** (OUT_W - 1)) - 1);
  localparam logic signed [PROD_W-1:0] OUT_MIN = -PROD_W'(2 ** (OUT_W - 1));

  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] shifted;

  assign prod    = PROD_W'(err) * $signed({1'b0, gain});
  assign shifted = prod >>> GAIN_FRAC_BITS;

  always_comb begin
    if (shifted > OUT_MAX)      scaled = OUT_MAX[OUT_W-1:0];
    else if (shifted < OUT_MIN) scaled = OUT_MIN[OUT_W-1:0];
    else                        scaled = shifted[OUT_W-1:0];
  end
endmodule

// File: rtl/nlg_gain_stage.sv
module nlg_gain_stage
  import nlg_pkg::*;
#(
  parameter int unsigned ERR_W      = 12,
  parameter int unsigned GAIN_W     = 5,
  parameter int unsigned OUT_W      = 12,
  parameter int unsigned NUM_LIMITS = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              err_valid,
  input  logic signed [ERR_W-1:0]           err_in,
  input  logic [NUM_LIMITS*ERR_W-1:0]       pos_limits,
  input  logic [NUM_LIMITS*ERR_W-1:0]       neg_limits,
  input  logic [(NUM_LIMITS+1)*GAIN_W-1:0]  pos_gains,
  input  logic [(NUM_LIMITS+1)*GAIN_W-1:0]  neg_gains,
  output logic                              scaled_valid,
  output logic signed [OUT_W-1:0]           scaled_err
);
  logic rst_meta, rst_sync_n;
  logic [GAIN_W-1:0]       gain;
  logic signed [OUT_W-1:0] scaled_d;
  logic signed [OUT_W-1:0] err_q, err_d;
  logic                    vld_d;

  // The reset asserts at once and releases on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  nlg_select #(.ERR_W(ERR_W), .GAIN_W(GAIN_W), .NUM_LIMITS(NUM_LIMITS)) u_select (
    .err(err_in), .pos_limits(pos_limits), .neg_limits(neg_limits),
    .pos_gains(pos_gains), .neg_gains(neg_gains), .gain(gain)
  );

  nlg_scale #(.ERR_W(ERR_W), .GAIN_W(GAIN_W), .OUT_W(OUT_W)) u_scale (
    .err(err_in), .gain(gain), .scaled(scaled_d)
  );

  // Next state
  always_comb begin
    vld_d = err_valid;
    err_d = err_q;
    if (err_valid) err_d = scaled_d;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      scaled_valid <= 1'b0;
      err_q        <= '0;
    end else begin
      scaled_valid <= vld_d;
      err_q        <= err_d;
    end
  end

  assign scaled_err = err_q;

  assert_valid_lag_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    err_valid |=> scaled_valid);
  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !err_valid |=> !scaled_valid);
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !err_valid |=> $stable(scaled_err));
  assert_zero_in_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (err_valid && err_in == '0) |=> scaled_err == '0);
  assert_neg_sign_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (err_valid && err_in < 0) |=> scaled_err <= 0);
  assert_pos_sign_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (err_valid && err_in > 0) |=> scaled_err >= 0);
endmodule

// File: tb/nlg_gain_stage_test.sv
module nlg_gain_stage_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic err_valid = 1'b0;
  logic signed [11:0] err_in = '0;
  logic [47:0] pos_limits, neg_limits;
  logic [24:0] pos_gains, neg_gains;
  logic scaled_valid;
  logic signed [11:0] scaled_err;

  int checks = 0;
  int errors = 0;
  int exp_q[$];
  string tag_q[$];
  int last_exp = 0;
  int plim[4], nlim[4], pg[5], ng[5];

  always #2 clk = ~clk;

  nlg_gain_stage uut (
    .clk(clk), .rst_n(rst_n), .err_valid(err_valid), .err_in(err_in),
    .pos_limits(pos_limits), .neg_limits(neg_limits),
    .pos_gains(pos_gains), .neg_gains(neg_gains),
    .scaled_valid(scaled_valid), .scaled_err(scaled_err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load_tables();
    for (int k = 0; k < 4; k++) begin
      pos_limits[k*12 +: 12] = 12'(plim[k]);
      neg_limits[k*12 +: 12] = 12'(nlim[k]);
    end
    for (int g = 0; g < 5; g++) begin
      pos_gains[g*5 +: 5] = 5'(pg[g]);
      neg_gains[g*5 +: 5] = 5'(ng[g]);
    end
  endtask

  function automatic int model(input int e);
    int mag, idx, code, p, q;
    mag = (e < 0) ? -e : e;
    idx = 0;
    for (int k = 0; k < 4; k++)
      if (mag > ((e < 0) ? nlim[k] : plim[k])) idx = k + 1;
    code = (e < 0) ? ng[idx] : pg[idx];
    p = e * code;
    q = (p >= 0) ? p / 4 : -((-p + 3) / 4);
    if (q > 2047) q = 2047;
    if (q < -2048) q = -2048;
    return q;
  endfunction

  task automatic send(input int e, input string req);
    @(posedge clk); #1;
    err_valid = 1'b1;
    err_in = 12'(e);
    exp_q.push_back(model(e));
    tag_q.push_back(req);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      err_valid = 1'b0;
    end
  endtask

  // Monitor and scoreboard.
  always @(negedge clk) begin
    if (rst_n && scaled_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2", int'(scaled_err), 0);
      end else begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        last_exp = e;
        check(int'(scaled_err) == e, t, int'(scaled_err), e);
      end
    end
  end

  initial begin
    #150000;
    check(1'b0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    plim = '{4, 10, 30, 60};
    nlim = '{4, 12, 30, 60};
    pg = '{2, 4, 8, 12, 16};
    ng = '{2, 4, 6, 12, 16};
    load_tables();
    repeat (3) @(posedge clk);
    #1;
    check(scaled_valid == 1'b0, "R1", int'(scaled_valid), 0);
    check(scaled_err == 0, "R1", int'(scaled_err), 0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    check(scaled_valid == 1'b0 && scaled_err == 0, "R1", int'(scaled_err), 0);

    send(3, "R7");      // 0.5 gain, 6/4 -> 1
    send(4, "R5");      // tie with limit 4 -> gain index 0 -> 2
    send(5, "R4");      // index 1 -> 5
    send(11, "R4");     // index 2, code 8 -> 22
    send(61, "R4");     // index 4, code 16 -> 244
    send(0, "R6");
    send(-3, "R7");     // -6/4 floors to -2
    send(-12, "R5");    // neg tie at 12 -> index 1 -> -12
    send(-13, "R6");    // index 2, code 6 -> -20
    send(-31, "R6");    // index 3, code 12 -> -93
    send(1000, "R8");   // clips to 2047
    send(-1000, "R8");  // clips to -2048
    send(2047, "R8");
    send(-2048, "R9");
    send(-5, "R6");     // neg limit 4 exceeded -> code 4 -> -5
    idle(4);
    check(exp_q.size() == 0, "R2", exp_q.size(), 0);
    check(scaled_valid == 1'b0, "R3", int'(scaled_valid), 0);
    check(int'(scaled_err) == last_exp, "R3", int'(scaled_err), last_exp);

    // Limits out of order: the highest index exceeded wins.
    plim = '{50, 10, 30, 5};
    load_tables();
    send(20, "R4");     // exceeds limits 1 and 3 -> index 4 -> 80
    send(7, "R4");      // exceeds limit 3 only -> index 4 -> 28
    send(5, "R5");      // equal to limit 3, exceeds none -> index 0 -> 2
    idle(1);
    send(-7, "R6");     // negative table unchanged -> index 1 -> -7
    idle(6);
    check(int'(scaled_err) == last_exp, "R3", int'(scaled_err), last_exp);
    check(exp_q.size() == 0, "R2", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule